// File: doc/BRIEF.md
# Collision and Carrier Loopback Monitor

This block supervises the collision input and the looped-back receive carrier of an attachment-unit port. A collision flag is raised in the same cycle that the collision input is active. The flag is then held for a fixed number of half-bit-time ticks after the most recent rising edge of that input, so that a collision oscillation appears as one continuous indication.

During a transmission the transmitted data is expected to return on the receive pair as carrier. The block tracks whether carrier became active during the transmission and whether it dropped again before the transmission ended. It makes this check only while the attachment-unit port is selected. On the falling edge of transmit-active it judges the transmission once, and a failure sets a sticky loss-of-carrier bit. That bit stays set until a clear strobe is given.

Top module: `coll_carrier_mon`

## Requirements
- R1: `coll_o` is high in every cycle in which `coll_i` is high, with no register delay.
- R2: After a clock edge that samples a rising edge of `coll_i` (high now, low at the previous edge), `coll_o` stays high while `coll_i` is low until three `half_tick_i` pulses have been sampled at later edges. It goes low after the edge that samples the third pulse. A tick sampled at the same edge as the rising edge is not counted.
- R3: A new rising edge of `coll_i` restarts the hold count at three ticks, whatever count remains.
- R4: With `port_sel_i` = 2'b00 (attachment-unit port), a transmission during which `rx_active_i` is never high sets `carrier_loss_o`. The bit is visible after the first edge that samples `tx_active_i` low following a high sample.
- R5: With port 2'b00 selected, a transmission in which `rx_active_i` goes high and then goes low while `tx_active_i` is still high sets `carrier_loss_o`.
- R6: With port 2'b00 selected, a transmission in which `rx_active_i` goes high and stays high until `tx_active_i` falls leaves `carrier_loss_o` unchanged. Carrier that appears only after `tx_active_i` falls counts as never seen.
- R7: When `port_sel_i` is any value other than 2'b00 at the edge that samples the fall of `tx_active_i`, `carrier_loss_o` is not set.
- R8: `carrier_loss_o` stays set until an edge samples `clear_i` high, after which it reads 0. If a new loss is judged at the same edge, the bit stays set.
- R9: After reset `carrier_loss_o` is 0 and no collision hold is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| coll_i | input | 1 | Digitized, qualified collision activity |
| rx_active_i | input | 1 | Receive carrier activity |
| tx_active_i | input | 1 | Transmission in progress |
| port_sel_i | input | 2 | Selected port; 2'b00 = attachment-unit port |
| half_tick_i | input | 1 | One-cycle pulse every half bit time |
| clear_i | input | 1 | Read-clear strobe for the loss bit |
| coll_o | output | 1 | Stretched collision indication |
| carrier_loss_o | output | 1 | Sticky loss-of-carrier error |

## Verification
The collision path is driven with three patterns:
- A single pulse followed by sparse ticks pins down the exact tick on which the hold ends.
- A second pulse in the middle of the hold shows whether the count is reloaded or only continues.
- A tick in the same cycle as the rising edge shows whether that tick is wrongly counted.

The carrier path is driven with four receive patterns under the attachment-unit port:
- no carrier;
- carrier held to the end;
- carrier that drops early;
- carrier that appears only after transmit ends.

These separate the never-seen case from the dropped case from a good transmission. The same missing-carrier transmission under another port, and a clear strobe coinciding with a new failure, expose a port check that is missing and a clear that wins over a set.

// File: rtl/coll_mon_pkg.sv
package coll_mon_pkg;
  typedef enum logic [1:0] {
    PORT_ATTACH = 2'b00,
    PORT_TWIST  = 2'b01,
    PORT_ALT0   = 2'b10,
    PORT_ALT1   = 2'b11
  } port_sel_e;

  localparam int unsigned HOLD_HALF_TICKS = 3;
endpackage

// File: rtl/coll_stretch.sv
module coll_stretch #(
  parameter int unsigned HOLD_TICKS = coll_mon_pkg::HOLD_HALF_TICKS
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic coll_i,
  input  logic half_tick_i,
  output logic coll_o
);
  localparam int unsigned CNT_W = $clog2(HOLD_TICKS + 1);
  localparam logic [CNT_W-1:0] RELOAD = CNT_W'(HOLD_TICKS);

  logic             coll_q;
  logic             rise;
  logic [CNT_W-1:0] hold_cnt_q;

  assign rise = coll_i & ~coll_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      coll_q     <= 1'b0;
      hold_cnt_q <= '0;
    end else begin
      coll_q <= coll_i;
      if (rise)
        hold_cnt_q <= RELOAD;  // reload wins over a coincident tick
      else if (half_tick_i && hold_cnt_q != '0)
        hold_cnt_q <= hold_cnt_q - 1'b1;
    end
  end

  assign coll_o = coll_i | (hold_cnt_q != '0);

  assert_hold_reload_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (coll_i && !coll_q) |=> (hold_cnt_q == RELOAD));
  assert_hold_bound_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hold_cnt_q <= RELOAD);
  assert_coll_pass_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    coll_i |-> coll_o);
  assert_hold_end_on_tick_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($fell(hold_cnt_q != '0)) |-> $past(half_tick_i));
endmodule

// File: rtl/carrier_loss_check.sv
module carrier_loss_check
  import coll_mon_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       rx_active_i,
  input  logic       tx_active_i,
  input  logic [1:0] port_sel_i,
  input  logic       clear_i,
  output logic       carrier_loss_o
);
  logic tx_q;
  logic seen_q;
  logic drop_q;
  logic tx_end;
  logic attach_sel;
  logic fail_now;
  logic loss_q;

  assign tx_end     = tx_q & ~tx_active_i;
  assign attach_sel = (port_sel_i == PORT_ATTACH);
  assign fail_now   = tx_end & attach_sel & (~seen_q | drop_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tx_q   <= 1'b0;
      seen_q <= 1'b0;
      drop_q <= 1'b0;
    end else begin
      tx_q <= tx_active_i;
      if (!tx_active_i) begin
        seen_q <= 1'b0;
        drop_q <= 1'b0;
      end else begin
        seen_q <= seen_q | rx_active_i;
        drop_q <= drop_q | (seen_q & ~rx_active_i);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)       loss_q <= 1'b0;
    else if (fail_now) loss_q <= 1'b1;  // new failure beats clear
    else if (clear_i)  loss_q <= 1'b0;
  end

  assign carrier_loss_o = loss_q;

  assert_loss_sticky_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (loss_q && !clear_i) |=> loss_q);
  assert_loss_clear_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (clear_i && !(tx_q && !tx_active_i)) |=> !loss_q);
  assert_loss_port_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(loss_q) |-> ($past(port_sel_i) == PORT_ATTACH));
  assert_loss_at_end_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(loss_q) |-> ($past(tx_q) && !$past(tx_active_i)));
endmodule

// File: rtl/coll_carrier_mon.sv
module coll_carrier_mon
  import coll_mon_pkg::*;
#(
  parameter int unsigned HOLD_TICKS = HOLD_HALF_TICKS
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       coll_i,
  input  logic       rx_active_i,
  input  logic       tx_active_i,
  input  logic [1:0] port_sel_i,
  input  logic       half_tick_i,
  input  logic       clear_i,
  output logic       coll_o,
  output logic       carrier_loss_o
);
  coll_stretch #(.HOLD_TICKS(HOLD_TICKS)) i_coll_stretch (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .coll_i      (coll_i),
    .half_tick_i (half_tick_i),
    .coll_o      (coll_o)
  );

  carrier_loss_check i_carrier_loss_check (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .rx_active_i    (rx_active_i),
    .tx_active_i    (tx_active_i),
    .port_sel_i     (port_sel_i),
    .clear_i        (clear_i),
    .carrier_loss_o (carrier_loss_o)
  );
endmodule

// File: tb/test_coll_carrier_mon.sv
module test_coll_carrier_mon;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       coll = 1'b0, rx = 1'b0, tx = 1'b0, tick = 1'b0, clr = 1'b0;
  logic [1:0] sel = 2'b00;
  logic       coll_o, loss_o;
  int         checks = 0, errors = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  coll_carrier_mon i_coll_carrier_mon (
    .clk_i(clk), .rst_ni(rst_n), .coll_i(coll), .rx_active_i(rx),
    .tx_active_i(tx), .port_sel_i(sel), .half_tick_i(tick), .clear_i(clr),
    .coll_o(coll_o), .carrier_loss_o(loss_o)
  );

  task automatic check(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic one_tick();
    tick = 1'b1; step(1); tick = 1'b0; step(1);
  endtask

  task automatic clear_loss();
    clr = 1'b1; step(1); clr = 1'b0; #1;
  endtask

  // mode 0: no carrier, 1: full carrier, 2: early drop, 3: carrier only after end
  task automatic run_tx(input logic [1:0] port, input int mode);
    sel = port;
    tx = 1'b1;
    for (int c = 0; c < 10; c++) begin
      case (mode)
        1: rx = (c >= 2);
        2: rx = (c >= 2 && c < 5);
        default: rx = 1'b0;
      endcase
      step(1);
    end
    tx = 1'b0;
    rx = (mode == 1 || mode == 3);
    step(1);
    rx = 1'b0;
    #1;
  endtask

  task automatic t_reset();
    #1;
    check("R9 loss after reset", loss_o, 1'b0);
    check("R9 coll after reset", coll_o, 1'b0);
  endtask

  task automatic t_single_pulse();
    coll = 1'b1; #1;
    check("R1 coll passes at once", coll_o, 1'b1);
    step(1); coll = 1'b0; #1;
    check("R2 held after pulse", coll_o, 1'b1);
    one_tick(); one_tick(); #1;
    check("R2 held after two ticks", coll_o, 1'b1);
    step(3); #1;
    check("R2 held without ticks", coll_o, 1'b1);
    one_tick(); #1;
    check("R2 low after third tick", coll_o, 1'b0);
  endtask

  task automatic t_retrigger();
    coll = 1'b1; step(1); coll = 1'b0;
    one_tick(); one_tick();
    coll = 1'b1; step(1); coll = 1'b0;
    one_tick(); one_tick(); #1;
    check("R3 reload keeps hold", coll_o, 1'b1);
    one_tick(); #1;
    check("R3 low after full reload", coll_o, 1'b0);
  endtask

  task automatic t_tick_at_rise();
    coll = 1'b1; tick = 1'b1; step(1); coll = 1'b0; tick = 1'b0;
    one_tick(); one_tick(); #1;
    check("R2 coincident tick not counted", coll_o, 1'b1);
    one_tick(); #1;
    check("R2 low after three later ticks", coll_o, 1'b0);
  endtask

  task automatic t_no_carrier();
    run_tx(2'b00, 0);
    check("R4 never seen sets loss", loss_o, 1'b1);
    step(4); #1;
    check("R8 loss sticky", loss_o, 1'b1);
    clear_loss();
    check("R8 clear resets loss", loss_o, 1'b0);
  endtask

  task automatic t_drop();
    run_tx(2'b00, 2);
    check("R5 early drop sets loss", loss_o, 1'b1);
    clear_loss();
  endtask

  task automatic t_good();
    run_tx(2'b00, 1);
    check("R6 full carrier no loss", loss_o, 1'b0);
    run_tx(2'b00, 3);
    check("R6 late carrier counts as missing", loss_o, 1'b1);
    clear_loss();
  endtask

  task automatic t_other_port();
    run_tx(2'b01, 0);
    check("R7 port 01 ignored", loss_o, 1'b0);
    run_tx(2'b11, 2);
    check("R7 port 11 ignored", loss_o, 1'b0);
  endtask

  task automatic t_clear_vs_set();
    run_tx(2'b00, 0);
    sel = 2'b00; tx = 1'b1; step(3);
    tx = 1'b0; clr = 1'b1; step(1); clr = 1'b0; #1;
    check("R8 set wins over clear", loss_o, 1'b1);
    clear_loss();
    check("R8 clear afterwards", loss_o, 1'b0);
  endtask

  initial begin
    fork
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog: got timeout expected completion");
          $display("Simulation finished: %0d checks, %0d errors", checks, errors);
          $finish;
        end
      end
    join_none
    step(2); rst_n = 1'b1; step(1);
    t_reset();
    t_single_pulse();
    t_retrigger();
    t_tick_at_rise();
    t_no_carrier();
    t_drop();
    t_good();
    t_other_port();
    t_clear_vs_set();
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule